// File: doc/BRIEF.md
# I2C Two-Register Slave

This block is the host-facing serial port of a small actuator controller. It connects a two-wire serial bus (7-bit addressing, standard and fast mode) to two 8-bit registers. The control register holds a six-bit output setpoint and two direction bits, and these drive the power stage directly. The fault register reports four latched fault flags from the protection logic and a summary flag. Writing a one to the top bit of the fault register sends a single-cycle clear pulse back to that logic.

The slave address is a fixed 7-bit base of 0x60 plus a strap code of 0 to 8. The byte that selects a write is therefore 0xC0 plus twice the code, and the byte that selects a read is one more. The code comes from two three-level strap pins, which are decoded outside this block. It is captured only while reset is asserted. A write transfer sends the address, then a sub-address byte that loads an internal pointer, then data bytes. A read transfer first writes the sub-address, then issues a repeated START with the read address. After every data byte the pointer moves on to the next sub-address.

SCL and SDA are sampled by the system clock. Each line passes through a synchronizer and a majority vote over three samples. The slave drives SDA only by pulling it low.

Top module: `i2c_dual_reg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 0x60 plus the captured strap code. For code 3 the write byte is 0xC6 and the read byte is 0xC7. A strap code above 8 is treated as 8 (byte 0xD0).
- R2: The strap code is sampled only while rst_n is low. A later change on strap_code_i has no effect on which address is acknowledged.
- R3: The general call address (byte 0x00) and any other non-matching address are not acknowledged. The slave then leaves SDA released until the next START.
- R4: After reset both registers read 0x00. A byte written to sub-address 0x00 sets setpoint_o to data bits 7..2, dir_b_o to bit 1 and dir_a_o to bit 0.
- R5: A register changes only after the falling SCL edge that ends the acknowledge of its data byte. A byte cut short by a STOP leaves every register unchanged.
- R6: A read returns, MSB first, the register selected by the pointer. The control register reads back the last value written.
- R7: Sub-address 0x01 reads as {0, 0, 0, limit, temp, uv, oc, any}, where any is the OR of the four fault inputs. Writing it with bit 7 set raises fault_clr_o for exactly one clock. Its other written bits have no effect.
- R8: Sub-addresses above 0x01 are acknowledged. Writes to them change nothing, and reads from them return 0x00.
- R9: After each data byte, written or read, the pointer advances by one, and it wraps from 0x01 to 0x00.
- R10: A STOP or a repeated START at any bit position returns the slave to idle. A master NACK after a read byte stops the slave from driving SDA.
- R11: A pulse on SCL that lasts a single clock is ignored and does not shift in a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; the strap code is captured while it is low |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line (the wired bus level) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_code_i | input | 4 | Decoded strap code, 0 to 8 |
| limit_flt_i | input | 1 | Latched extended-current-limit fault |
| temp_flt_i | input | 1 | Over-temperature fault |
| uv_flt_i | input | 1 | Undervoltage fault |
| oc_flt_i | input | 1 | Latched overcurrent fault |
| setpoint_o | output | 6 | Output voltage setpoint code |
| dir_b_o | output | 1 | Bridge direction bit B (control bit 1) |
| dir_a_o | output | 1 | Bridge direction bit A (control bit 0) |
| fault_clr_o | output | 1 | One-cycle request to clear the latched faults |

## Verification
The bound checker checks the following on every cycle. The clear pulse never lasts longer than one clock. SDA is only grabbed or released while the filtered SCL is low. The control outputs change only in the SCL low phase. A STOP always leaves SDA released.

Other behaviours can only be shown by the bench's transfers on the bus. These are address matching and the clamping of the strap code, the immunity to strap changes after reset, readback through repeated START, pointer wrap, the silence of reserved sub-addresses, discarding of truncated bytes, and glitch rejection. In these transfers a behavioural model of the registers is compared with the outputs on every clock.

// File: rtl/i2cr_pkg.sv
// Shared types and constants for the two-register serial slave.
// Assumes 7-bit addressing; sub-addresses are full bytes.
package i2cr_pkg;
    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RECV,
        BS_ACK,
        BS_SEND,
        BS_MACK
    } bus_state_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_SUB,
        BK_DATA
    } byte_kind_t;

    localparam logic [6:0] ADDR_BASE7 = 7'h60;
    localparam logic [7:0] SUB_CTRL   = 8'h00;
    localparam logic [7:0] SUB_FAULT  = 8'h01;
endpackage

// File: rtl/i2cr_pin_filter.sv
// Input conditioner for one bus line: a synchronizer chain followed by
// a majority vote over the last VOTE_TAPS synchronized samples.
// Assumes the line idles high; reset loads all stages with 1.
module i2cr_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int HALF = VOTE_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   win_q;
    logic                   vote;
    int                     ones;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Keep a short history of synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= {win_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    end

    // Count the ones in the window to form the majority.
    always_comb begin
        ones = 0;
        for (int k = 0; k < VOTE_TAPS; k++) ones += int'(win_q[k]);
        vote = (ones > HALF);
    end

    // Register the vote so that downstream edge detection sees clean levels.
    always_ff @(posedge clk) begin
        if (!rst_n) clean_o <= 1'b1;
        else        clean_o <= vote;
    end
endmodule

// File: rtl/i2cr_bus_engine.sv
// Bus protocol engine: detects START and STOP, shifts bytes, matches the
// address, drives ACK and read data, and owns the sub-address pointer.
// Assumes filtered SCL and SDA. A register write is issued only at the
// SCL fall that ends the acknowledge clock. Read data is taken from
// rd_data_i, which is combinational on rd_addr_o, when a byte is loaded.
module i2cr_bus_engine
    import i2cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] own_addr_i,
    output logic       sda_pull_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i
);
    bus_state_t state;
    byte_kind_t kind;
    logic       scl_q, sda_q;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, txbyte, ptr;
    logic       rw, nak;
    logic       start_ev, stop_ev, scl_rise, scl_fall;

    function automatic logic [7:0] step_ptr(input logic [7:0] p);
        return (p == SUB_FAULT) ? SUB_CTRL : p + 8'd1;
    endfunction

    // Remember the previous line levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode bus events from the current and previous levels.
    always_comb begin
        start_ev = scl_q & scl_i & sda_q & ~sda_i;
        stop_ev  = scl_q & scl_i & ~sda_q & sda_i;
        scl_rise = ~scl_q & scl_i;
        scl_fall = scl_q & ~scl_i;
    end

    assign rd_addr_o = ptr;

    // Transfer sequencing: receive, acknowledge, transmit, master acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= BS_IDLE;
            kind       <= BK_ADDR;
            bit_cnt    <= '0;
            shreg      <= '0;
            txbyte     <= '0;
            ptr        <= SUB_CTRL;
            rw         <= 1'b0;
            nak        <= 1'b0;
            sda_pull_o <= 1'b0;
            wr_stb_o   <= 1'b0;
            wr_addr_o  <= '0;
            wr_data_o  <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (start_ev) begin
                state      <= BS_RECV;
                kind       <= BK_ADDR;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
            end else if (stop_ev) begin
                state      <= BS_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (state)
                    BS_RECV: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_i};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (kind == BK_ADDR && shreg[7:1] != own_addr_i) begin
                                state <= BS_IDLE;
                            end else begin
                                state      <= BS_ACK;
                                sda_pull_o <= 1'b1;
                                if (kind == BK_ADDR) rw <= shreg[0];
                            end
                        end
                    end
                    BS_ACK: begin
                        if (scl_fall) begin
                            sda_pull_o <= 1'b0;
                            bit_cnt    <= '0;
                            state      <= BS_RECV;
                            case (kind)
                                BK_ADDR: begin
                                    if (rw) begin
                                        state      <= BS_SEND;
                                        txbyte     <= rd_data_i;
                                        sda_pull_o <= ~rd_data_i[7];
                                        ptr        <= step_ptr(ptr);
                                    end else begin
                                        kind <= BK_SUB;
                                    end
                                end
                                BK_SUB: begin
                                    ptr  <= shreg;
                                    kind <= BK_DATA;
                                end
                                default: begin
                                    wr_stb_o  <= 1'b1;
                                    wr_addr_o <= ptr;
                                    wr_data_o <= shreg;
                                    ptr       <= step_ptr(ptr);
                                end
                            endcase
                        end
                    end
                    BS_SEND: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_pull_o <= 1'b0;
                                state      <= BS_MACK;
                            end else begin
                                txbyte     <= {txbyte[6:0], 1'b0};
                                sda_pull_o <= ~txbyte[6];
                                bit_cnt    <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    BS_MACK: begin
                        if (scl_rise) begin
                            nak <= sda_i;
                        end else if (scl_fall) begin
                            if (!nak) begin
                                state      <= BS_SEND;
                                txbyte     <= rd_data_i;
                                sda_pull_o <= ~rd_data_i[7];
                                ptr        <= step_ptr(ptr);
                                bit_cnt    <= '0;
                            end else begin
                                state <= BS_IDLE;
                            end
                        end
                    end
                    default: state <= BS_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2cr_reg_bank.sv
// Register bank: the control register, a read view of the fault flags,
// and the self-clearing clear request. Assumes at most one write strobe
// per byte time.
module i2cr_reg_bank
    import i2cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    input  logic [3:0] flags_i,
    output logic [7:0] ctrl_o,
    output logic       clr_o
);
    logic [7:0] fault_view;

    // Store control writes and raise the clear request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
            clr_o  <= 1'b0;
        end else begin
            clr_o <= 1'b0;
            if (wr_stb_i) begin
                if (wr_addr_i == SUB_CTRL)                    ctrl_o <= wr_data_i;
                else if (wr_addr_i == SUB_FAULT && wr_data_i[7]) clr_o  <= 1'b1;
            end
        end
    end

    // Select the read data; unmapped sub-addresses read zero.
    always_comb begin
        fault_view = {3'b000, flags_i, |flags_i};
        case (rd_addr_i)
            SUB_CTRL:  rd_data_o = ctrl_o;
            SUB_FAULT: rd_data_o = fault_view;
            default:   rd_data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2c_dual_reg_slave.sv
// Top level of the two-register serial slave. Filters both bus lines,
// captures the strap code while reset is held, forms the own address and
// connects the protocol engine to the register bank.
// Assumes strap_code_i is already decoded to 0..CODE_MAX.
module i2c_dual_reg_slave
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3,
    parameter int CODE_MAX    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [3:0] strap_code_i,
    input  logic       limit_flt_i,
    input  logic       temp_flt_i,
    input  logic       uv_flt_i,
    input  logic       oc_flt_i,
    output logic [5:0] setpoint_o,
    output logic       dir_b_o,
    output logic       dir_a_o,
    output logic       fault_clr_o
);
    localparam int         NUM_LINES = 2;
    localparam logic [3:0] CODE_TOP  = 4'(CODE_MAX);

    logic [NUM_LINES-1:0] raw_lines, flt_lines;
    logic       scl_flt, sda_flt;
    logic [3:0] code_q;
    logic [6:0] own_addr;
    logic       wr_stb;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data, ctrl;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cr_pin_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_TAPS  (VOTE_TAPS)
        ) u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[1];
    assign sda_flt = flt_lines[0];

    // Capture the strap code while reset is held, clamped to the legal range.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= (strap_code_i > CODE_TOP) ? CODE_TOP : strap_code_i;
    end

    assign own_addr = ADDR_BASE7 + 7'(code_q);

    i2cr_bus_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_flt),
        .sda_i     (sda_flt),
        .own_addr_i(own_addr),
        .sda_pull_o(sda_pull_o),
        .wr_stb_o  (wr_stb),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data)
    );

    i2cr_reg_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .flags_i  ({limit_flt_i, temp_flt_i, uv_flt_i, oc_flt_i}),
        .ctrl_o   (ctrl),
        .clr_o    (fault_clr_o)
    );

    assign setpoint_o = ctrl[7:2];
    assign dir_b_o    = ctrl[1];
    assign dir_a_o    = ctrl[0];
endmodule

// File: rtl/i2cr_slave_checks.sv
// Protocol checker for the two-register slave, attached with bind.
// It observes the filtered bus lines, the SDA pull and the outputs.
module i2cr_slave_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_f,
    input logic       sda_pull,
    input logic       clr,
    input logic [7:0] ctrl
);
    AST_CLR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr); // R7

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_f); // R1

    AST_CTRL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> !scl_f); // R5

    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_f) && scl_f && $past(scl_f)) |=> !sda_pull); // R10
endmodule

bind i2c_dual_reg_slave i2cr_slave_checks u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_flt),
    .sda_f   (sda_flt),
    .sda_pull(sda_pull_o),
    .clr     (fault_clr_o),
    .ctrl    ({setpoint_o, dir_b_o, dir_a_o})
);

// File: tb/i2c_dual_reg_slave_test.sv
// Bench: a bus master drives transfers; a behavioural register model is
// compared with the control outputs and the clear-pulse count every clock.
module i2c_dual_reg_slave_test;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [3:0] strap = 4'd3;
    logic lim = 1'b0, tmp = 1'b0, uv = 1'b0, oc = 1'b0;
    logic sda_pull, clr;
    logic [5:0] setpoint;
    logic dir_b, dir_a;
    wire  sda_line = sda_m & ~sda_pull;

    int checks = 0, errors = 0, settle = 0, cyc = 0;
    int got_clr = 0, exp_clr = 0;
    logic [7:0] exp_ctrl = 8'h00;
    logic [7:0] mptr = 8'h00;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_dual_reg_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_code_i(strap),
        .limit_flt_i(lim), .temp_flt_i(tmp), .uv_flt_i(uv), .oc_flt_i(oc),
        .setpoint_o(setpoint), .dir_b_o(dir_b), .dir_a_o(dir_a),
        .fault_clr_o(clr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Per-clock comparison against the model (R4, R5, R7).
    always @(negedge clk) begin
        if (clr === 1'b1) got_clr++;
        if (settle > 0) settle--;
        else if (rst_n && !done) begin
            checks++;
            if ({setpoint, dir_b, dir_a} !== exp_ctrl || got_clr != exp_clr) begin
                errors++;
                $display("FAIL R5 per-clock actual=%0h/%0d expected=%0h/%0d",
                         {setpoint, dir_b, dir_a}, got_clr, exp_ctrl, exp_clr);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_up();
        end
    end

    function automatic logic [7:0] fault_exp();
        return {3'b000, lim, tmp, uv, oc, (lim | tmp | uv | oc)};
    endfunction
    function automatic logic [7:0] model_read(input logic [7:0] p);
        return (p == 8'h00) ? exp_ctrl : (p == 8'h01) ? fault_exp() : 8'h00;
    endfunction
    function automatic logic [7:0] step(input logic [7:0] p);
        return (p == 8'h01) ? 8'h00 : p + 8'd1;
    endfunction
    task automatic model_write(input logic [7:0] p, input logic [7:0] d);
        if (p == 8'h00) exp_ctrl = d;
        if (p == 8'h01 && d[7]) exp_clr++;
        settle = 12;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic do_start;
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask
    task automatic do_stop;
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask
    task automatic clock_bit(input logic v, output logic seen);
        sda_m = v; tick(Q); scl_m = 1'b1; tick(Q);
        seen = sda_line; tick(Q); scl_m = 1'b0; tick(2);
    endtask
    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) clock_bit(b[i], s);
    endtask
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask
    task automatic recv_byte(output logic [7:0] b, input logic nack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(nack, s);
    endtask
    task automatic addr(input logic [7:0] ab, input logic exp_ack, input string tag);
        logic a;
        do_start();
        send_byte(ab, a);
        check(tag, a, exp_ack);
    endtask
    task automatic wsub(input logic [7:0] p, input string tag);
        logic a;
        send_byte(p, a);
        check(tag, a, 1'b1);
        mptr = p;
    endtask
    task automatic wdata(input logic [7:0] d, input string tag);
        logic a;
        send_byte(d, a);
        model_write(mptr, d);
        mptr = step(mptr);
        check(tag, a, 1'b1);
    endtask
    task automatic rdata(input logic nack, input string tag);
        logic [7:0] b;
        recv_byte(b, nack);
        check(tag, b, model_read(mptr));
        mptr = step(mptr);
    endtask
    task automatic do_reset(input logic [3:0] code);
        rst_n = 1'b0; strap = code; exp_ctrl = 8'h00; mptr = 8'h00; settle = 20;
        tick(5); rst_n = 1'b1; tick(5);
        check("R4 reset ctrl", {setpoint, dir_b, dir_a}, 8'h00);
        check("R4 reset sda_pull", sda_pull, 1'b0);
        check("R4 reset clear", clr, 1'b0);
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        do_reset(4'd3);

        // R1/R4: write control through write address 0xC6.
        addr(8'hC6, 1'b1, "R1 write address ack");
        wsub(8'h00, "R4 sub ack");
        wdata(8'hA5, "R4 data ack");
        do_stop(); tick(20);
        check("R4 setpoint", setpoint, 6'h29);
        check("R4 dir_b", dir_b, 1'b0);
        check("R4 dir_a", dir_a, 1'b1);

        // R6: readback through repeated START and read address 0xC7.
        addr(8'hC6, 1'b1, "R6 addr");
        wsub(8'h00, "R6 sub");
        addr(8'hC7, 1'b1, "R1 read address ack");
        rdata(1'b1, "R6 control readback");
        do_stop();

        // R1: another code's address; R3: general call.
        addr(8'hC4, 1'b0, "R1 foreign address nack");
        do_stop();
        addr(8'h00, 1'b0, "R3 general call nack");
        send_byte(8'h55, a);
        check("R3 silent after general call", a, 1'b0);
        do_stop();

        // R7: fault view, clear pulse, ignored bits.
        lim = 1'b1; uv = 1'b1;
        addr(8'hC6, 1'b1, "R7 addr");
        wsub(8'h01, "R7 sub");
        addr(8'hC7, 1'b1, "R7 read addr");
        rdata(1'b1, "R7 fault read");
        do_stop();
        addr(8'hC6, 1'b1, "R7 addr");
        wsub(8'h01, "R7 sub");
        wdata(8'h80, "R7 clear write");
        do_stop(); tick(20);
        check("R7 one clear pulse", got_clr, 1);
        addr(8'hC6, 1'b1, "R7 addr");
        wsub(8'h01, "R7 sub");
        wdata(8'h7F, "R7 no-clear write");
        do_stop(); tick(20);
        check("R7 no pulse without bit7", got_clr, 1);
        addr(8'hC6, 1'b1, "R7 addr");
        wsub(8'h01, "R7 sub");
        addr(8'hC7, 1'b1, "R7 read addr");
        rdata(1'b1, "R7 fault unchanged by write");
        do_stop();

        // R9: sequential write wraps 0x01 -> 0x00, sequential read.
        addr(8'hC6, 1'b1, "R9 addr");
        wsub(8'h01, "R9 sub");
        wdata(8'h00, "R9 fault byte");
        wdata(8'h3E, "R9 wrapped control byte");
        do_stop(); tick(20);
        check("R9 control after wrap", {setpoint, dir_b, dir_a}, 8'h3E);
        addr(8'hC6, 1'b1, "R9 addr");
        wsub(8'h00, "R9 sub");
        addr(8'hC7, 1'b1, "R9 read addr");
        rdata(1'b0, "R9 read byte 0");
        rdata(1'b0, "R9 read byte 1");
        rdata(1'b1, "R9 read byte 2 wrapped");
        do_stop();

        // R8: unmapped sub-address.
        addr(8'hC6, 1'b1, "R8 addr");
        wsub(8'h05, "R8 unmapped sub ack");
        wdata(8'hFF, "R8 unmapped data ack");
        do_stop(); tick(20);
        check("R8 control untouched", {setpoint, dir_b, dir_a}, 8'h3E);
        addr(8'hC6, 1'b1, "R8 addr");
        wsub(8'h05, "R8 sub");
        addr(8'hC7, 1'b1, "R8 read addr");
        rdata(1'b1, "R8 unmapped reads zero");
        do_stop();

        // R5: truncated byte then STOP.
        addr(8'hC6, 1'b1, "R5 addr");
        wsub(8'h00, "R5 sub");
        send_bits(8'hF0, 4);
        do_stop(); tick(20);
        check("R5 truncated byte discarded", {setpoint, dir_b, dir_a}, 8'h3E);

        // R5: no update before the acknowledge clock ends.
        addr(8'hC6, 1'b1, "R5 addr");
        wsub(8'h00, "R5 sub");
        send_bits(8'h11, 8);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        check("R5 ack driven", sda_line, 1'b0);
        check("R5 unchanged during ack", {setpoint, dir_b, dir_a}, 8'h3E);
        tick(Q); scl_m = 1'b0; tick(2);
        model_write(8'h00, 8'h11);
        do_stop(); tick(20);
        check("R5 updated after ack", {setpoint, dir_b, dir_a}, 8'h11);

        // R10: repeated START in mid-byte restarts the transfer.
        addr(8'hC6, 1'b1, "R10 addr");
        wsub(8'h00, "R10 sub");
        send_bits(8'hFF, 3);
        addr(8'hC6, 1'b1, "R10 restart addr");
        wsub(8'h00, "R10 sub");
        wdata(8'h42, "R10 data");
        do_stop(); tick(20);
        check("R10 write after restart", {setpoint, dir_b, dir_a}, 8'h42);

        // R10: master NACK ends transmission.
        addr(8'hC6, 1'b1, "R10 addr");
        wsub(8'h00, "R10 sub");
        addr(8'hC7, 1'b1, "R10 read addr");
        rdata(1'b1, "R10 read before nack");
        recv_byte(b, 1'b1);
        check("R10 silent after nack", b, 8'hFF);
        do_stop();

        // R11: single-clock SCL glitch inside bit 4 of a data byte.
        addr(8'hC6, 1'b1, "R11 addr");
        wsub(8'h00, "R11 sub");
        begin
            logic s;
            for (int i = 7; i >= 0; i--) begin
                if (i == 4) begin
                    sda_m = 1'b1; tick(6); scl_m = 1'b1; tick(1); scl_m = 1'b0;
                    tick(Q - 7); scl_m = 1'b1; tick(Q); tick(Q); scl_m = 1'b0; tick(2);
                end else begin
                    clock_bit(8'h9C >> i, s);
                end
            end
            clock_bit(1'b1, s);
            model_write(8'h00, 8'h9C);
            check("R11 glitch byte ack", s, 1'b0);
        end
        do_stop(); tick(20);
        check("R11 glitch ignored", {setpoint, dir_b, dir_a}, 8'h9C);

        // R2: strap change after reset is ignored.
        strap = 4'd0;
        addr(8'hC0, 1'b0, "R2 new strap address ignored");
        do_stop();
        addr(8'hC6, 1'b1, "R2 captured address kept");
        do_stop();

        // R1: out-of-range code clamps to 8 (0xD0).
        do_reset(4'd12);
        addr(8'hD0, 1'b1, "R1 clamped code address");
        do_stop();
        addr(8'hC6, 1'b0, "R1 old address rejected");
        do_stop();
        tick(20);
        finish_up();
    end
endmodule